// File: doc/BRIEF.md
# Pad interrupt router with polarity filter

The router watches a wide bus of pad input lines and forwards a chosen subset onto eight upstream interrupt channels. Every channel picks its own source pad through an 8-bit select value. It corrects the source's polarity, can optionally require the source to hold still before a change counts, and then delivers the result as an active-high level or as a one-cycle rising pulse. A downstream interrupt controller that accepts only high levels or rising edges can therefore serve low-level and falling-edge sources too. Only one edge direction per channel is possible: the invert bit chooses which one.

Pads enter through a two-flop synchroniser. The number of selectable pads, `NUM_PADS`, is a build parameter of at most 256. Software programs the block through a small word-addressed register port with combinational read-back. Each channel carries a deglitch state machine with two states. `FLT_STEADY` means the filtered value agrees with the input. `FLT_QUALIFY` means a disagreement is being timed. The transitions are as follows:
- steady→qualify: the input differs from the filtered value and the hold threshold is above one cycle.
- qualify→steady (drop): the input returns to the filtered value before the threshold.
- qualify→steady (commit): the input has disagreed for the full threshold, and the filtered value takes the input's value.
- steady→steady (commit): the filter is bypassed, so a difference is taken at once.

Top module: `pirq_router`

## Requirements
- R1: After reset all four configuration words read as zero. Every channel is in level mode, not inverted, with pad 0 selected and the filter bypassed, and all `irq_o` bits are 0 while pads are low.
- R2: The word at byte address 0x4 holds the 8-bit source selects of channels 0 to 3, and the word at 0x8 holds those of channels 4 to 7. Channel c uses bits [(c mod 4)*8 +: 8]. All 32 bits of both words are writable and read back.
- R3: In the word at 0x0, bit c set puts channel c in edge mode and bit 16+c set inverts its source. Bits 8 to 15 and 24 to 31 ignore writes and always read zero.
- R4: The word at 0xC holds a 4-bit hold value F for channel c at bits [c*4 +: 4]. All 32 bits are writable and read back.
- R5: In level mode with F=0, `irq_o[c]` equals the selected pad XOR the invert bit. A pad change driven between clock edges shows on the output after the third following rising edge.
- R6: In edge mode, `irq_o[c]` is high for exactly one cycle each time the filtered, polarity-corrected signal goes from 0 to 1. This is a rising pad when not inverted and a falling pad when inverted. Nothing is produced for the opposite direction.
- R7: A select value at or above `NUM_PADS` makes the channel's corrected input constant 0, whatever the invert bit is.
- R8: With F nonzero, the filtered value changes only after the corrected input has differed from it on 2*F consecutive rising edges. A shorter excursion leaves the output untouched.
- R9: Each pad passes two synchronising flops before selection, so the output does not react to a pad change within the first two rising edges after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PADS | Asynchronous pad lines |
| cfg_addr_i | input | 4 | Byte address of the configuration word (bits 3:2 decoded) |
| cfg_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Combinational read data of the addressed word |
| irq_o | output | 8 | Active-high channel outputs |

## Verification
The hardest condition to reach is a deglitch window that is cut short by a configuration change. This happens when the hold value drops below the count already reached while a channel is in `FLT_QUALIFY`. A channel can also have its select moved while a disagreement is being timed. The stimulus reaches these cases by toggling the watched pads at several rates, some fast enough to produce glitches shorter than the window and some slow enough to commit. At random times it also rewrites the hold, select and mode words. A behavioural model in the bench tracks every channel's counter and compares all outputs and the read data on every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned NUM_CH   = 8;
    localparam int unsigned SEL_W    = 8;
    localparam int unsigned FLT_W    = 4;
    localparam int unsigned CNT_W    = FLT_W + 1;
    localparam int unsigned MAX_PADS = 1 << SEL_W;
    localparam int unsigned WORD_W   = 32;

    typedef enum logic [0:0] {
        FLT_STEADY  = 1'b0,
        FLT_QUALIFY = 1'b1
    } flt_state_e;

    typedef enum logic [1:0] {
        W_MODE   = 2'd0,
        W_SEL_LO = 2'd1,
        W_SEL_HI = 2'd2,
        W_HOLD   = 2'd3
    } reg_word_e;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [3:0]              addr_i,
    input  logic                    we_i,
    input  logic [WORD_W-1:0]       wdata_i,
    output logic [WORD_W-1:0]       rdata_o,
    output logic [NUM_CH-1:0]       edge_en_o,
    output logic [NUM_CH-1:0]       invert_o,
    output logic [NUM_CH*SEL_W-1:0] sel_o,
    output logic [NUM_CH*FLT_W-1:0] hold_o
);
    localparam logic [15:0]       HALF_MASK = 16'((1 << NUM_CH) - 1);
    localparam logic [WORD_W-1:0] MODE_MASK = {HALF_MASK, HALF_MASK};

    logic [WORD_W-1:0] mode_q, sel_lo_q, sel_hi_q, hold_q;
    reg_word_e         word;

    assign word = reg_word_e'(addr_i[3:2]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q   <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            hold_q   <= '0;
        end else if (we_i) begin
            unique case (word)
                W_MODE:   mode_q   <= wdata_i & MODE_MASK;
                W_SEL_LO: sel_lo_q <= wdata_i;
                W_SEL_HI: sel_hi_q <= wdata_i;
                W_HOLD:   hold_q   <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (word)
            W_MODE:   rdata_o = mode_q;
            W_SEL_LO: rdata_o = sel_lo_q;
            W_SEL_HI: rdata_o = sel_hi_q;
            W_HOLD:   rdata_o = hold_q;
            default:  rdata_o = '0;
        endcase
    end

    assign edge_en_o = mode_q[NUM_CH-1:0];
    assign invert_o  = mode_q[16 +: NUM_CH];
    assign sel_o     = {sel_hi_q, sel_lo_q};
    assign hold_o    = hold_q;

    AST_MODE_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word == W_MODE) |-> (rdata_o[15:8] == 8'h00 && rdata_o[31:24] == 8'h00)); // R3
endmodule

// File: rtl/pirq_chan.sv
module pirq_chan
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PADS = 133
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [MAX_PADS-1:0] pads_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                edge_en_i,
    input  logic                invert_i,
    input  logic [FLT_W-1:0]    hold_i,
    output logic                irq_o
);
    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d, filt_prev_q;
    logic             in_range, corr, differ, reach;
    logic [CNT_W-1:0] thr;

    assign in_range = (int'(sel_i) < int'(NUM_PADS));
    assign corr     = in_range & (pads_i[sel_i] ^ invert_i);
    assign thr      = (hold_i == '0) ? CNT_W'(1) : {hold_i, 1'b0};
    assign differ   = (corr != filt_q);
    assign reach    = ((cnt_q + CNT_W'(1)) >= thr);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (differ) begin
                    if (reach) begin
                        filt_d = corr;
                        cnt_d  = '0;
                    end else begin
                        state_d = FLT_QUALIFY;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            FLT_QUALIFY: begin
                if (!differ) begin
                    state_d = FLT_STEADY;
                    cnt_d   = '0;
                end else if (reach) begin
                    state_d = FLT_STEADY;
                    filt_d  = corr;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = FLT_STEADY;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= FLT_STEADY;
            cnt_q       <= '0;
            filt_q      <= 1'b0;
            filt_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            filt_q      <= filt_d;
            filt_prev_q <= filt_q;
        end
    end

    always_comb begin
        if (edge_en_i) irq_o = filt_q & ~filt_prev_q;
        else           irq_o = filt_q;
    end

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_en_i && irq_o) |=> !(edge_en_i && irq_o)); // R6
    AST_HOLD_WHEN_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !differ |=> $stable(filt_q)); // R8
    AST_BYPASS_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i == '0 && differ) |=> (filt_q == $past(corr))); // R5
    AST_OOR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_range && !filt_q) |=> !filt_q); // R7
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PADS = 133
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic [3:0]          cfg_addr_i,
    input  logic                cfg_we_i,
    input  logic [31:0]         cfg_wdata_i,
    output logic [31:0]         cfg_rdata_o,
    output logic [7:0]          irq_o
);
    logic [NUM_PADS-1:0]     pad_sync;
    logic [MAX_PADS-1:0]     pad_ext;
    logic [NUM_CH-1:0]       edge_en, invert;
    logic [NUM_CH*SEL_W-1:0] sel;
    logic [NUM_CH*FLT_W-1:0] hold;

    pirq_sync #(.W(NUM_PADS)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_i),
        .q_o    (pad_sync)
    );

    always_comb begin
        pad_ext                = '0;
        pad_ext[NUM_PADS-1:0]  = pad_sync;
    end

    pirq_regs regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (cfg_addr_i),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (cfg_rdata_o),
        .edge_en_o (edge_en),
        .invert_o  (invert),
        .sel_o     (sel),
        .hold_o    (hold)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pirq_chan #(.NUM_PADS(NUM_PADS)) chan_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .pads_i    (pad_ext),
            .sel_i     (sel[c*SEL_W +: SEL_W]),
            .edge_en_i (edge_en[c]),
            .invert_i  (invert[c]),
            .hold_i    (hold[c*FLT_W +: FLT_W]),
            .irq_o     (irq_o[c])
        );
    end
endmodule

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;
    localparam int CLK_P = 10;
    localparam int NP    = 133;
    localparam int WDOG  = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pad = '0;
    logic [3:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [7:0]    irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit cmp_on   = 0;

    always #(CLK_P/2) clk = ~clk;

    pirq_router #(.NUM_PADS(NP)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pad_i(pad),
        .cfg_addr_i(addr), .cfg_we_i(we), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0]   m_reg [4];
    logic [NP-1:0] m_s1, m_s2;
    int            m_cnt  [8];
    bit            m_f    [8];
    bit            m_prev [8];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] = '0;
            m_s1 = '0; m_s2 = '0;
            for (int c = 0; c < 8; c++) begin
                m_cnt[c] = 0; m_f[c] = 0; m_prev[c] = 0;
            end
        end else begin
            for (int c = 0; c < 8; c++) begin
                int s, fl, thr;
                bit pc;
                s  = int'(m_reg[1 + c/4][(c%4)*8 +: 8]);
                fl = int'(m_reg[3][c*4 +: 4]);
                pc = 0;
                if (s < NP) pc = m_s2[s] ^ m_reg[0][16+c];
                thr = (fl == 0) ? 1 : 2*fl;
                m_prev[c] = m_f[c];
                if (pc != m_f[c]) begin
                    if (m_cnt[c] + 1 >= thr) begin
                        m_f[c] = pc; m_cnt[c] = 0;
                    end else m_cnt[c] = m_cnt[c] + 1;
                end else m_cnt[c] = 0;
            end
            m_s2 = m_s1;
            m_s1 = pad;
            if (we) begin
                if (addr[3:2] == 2'd0) m_reg[0] = wdata & 32'h00FF_00FF;
                else m_reg[addr[3:2]] = wdata;
            end
        end
    end

    function automatic bit exp_irq(int c);
        return m_reg[0][c] ? (m_f[c] & !m_prev[c]) : m_f[c];
    endfunction

    function automatic string irq_tag(int c);
        int s;
        s = int'(m_reg[1 + c/4][(c%4)*8 +: 8]);
        if (s >= NP) return "R7";
        if (m_reg[0][c]) return "R6";
        if (m_reg[3][c*4 +: 4] != 0) return "R8";
        return "R5";
    endfunction

    function automatic string rd_tag(logic [1:0] w);
        case (w)
            2'd0:    return "R3";
            2'd3:    return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n && cmp_on && !done) begin
            check(rd_tag(addr[3:2]), "rdata", rdata, m_reg[addr[3:2]]);
            for (int c = 0; c < 8; c++)
                check(irq_tag(c), $sformatf("irq[%0d]", c), 32'(irq[c]), 32'(exp_irq(c)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic run_random(int cycles, int rate);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            foreach (pad[p]) if (($urandom % rate) == 0) pad[p] = ~pad[p];
            addr = 4'($urandom % 4) << 2;
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int w = 0; w < 4; w++) begin
            @(negedge clk); addr = 4'(w << 2); #(CLK_P/4);
            check("R1", "reset rdata", rdata, 32'h0);
        end
        check("R1", "reset irq", 32'(irq), 32'h0);

        // R9: synchroniser latency, channel 0 on pad 0, level, bypass
        @(negedge clk); pad[0] = 1'b1;
        @(posedge clk); @(posedge clk); #(CLK_P/4);
        check("R9", "irq[0] before sync", 32'(irq[0]), 32'h0);
        @(posedge clk); #(CLK_P/4);
        check("R5", "irq[0] after three edges", 32'(irq[0]), 32'h1);
        @(negedge clk); pad[0] = 1'b0;
        repeat (4) @(negedge clk);
        cmp_on = 1;

        // R3: unused mode bits ignore writes
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h0, 32'h0);
        // R2 and R4: full-word read-back
        wr(4'h4, 32'hA55A_3CC3);
        wr(4'h8, 32'h5AA5_C33C);
        wr(4'hC, 32'hDEAD_BEEF);

        // scenario: ch0 pad5 level, ch1 pad5 inverted level, ch2 pad7 rising,
        // ch3 pad7 falling, ch4 out-of-range inverted, ch5 last pad,
        // ch6 pad9 hold 3, ch7 pad9 rising with hold 1
        wr(4'h4, {8'd7, 8'd7, 8'd5, 8'd5});
        wr(4'h8, {8'd9, 8'd9, 8'd132, 8'd200});
        wr(4'hC, {4'd1, 4'd3, 24'h0});
        wr(4'h0, 32'h001A_008C);
        run_random(2000, 4);
        run_random(2000, 12);
        run_random(2000, 40);

        // reconfiguration in flight: hold values and selects change while timing
        for (int k = 0; k < 40; k++) begin
            wr(4'($urandom % 4) << 2, $urandom);
            run_random(60, 3 + (k % 20));
        end
        // R7: out-of-range select everywhere, then long activity
        wr(4'h4, 32'hFFFE_9A86);
        wr(4'h8, 32'h8586_FF90);
        run_random(500, 5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule